// File: doc/BRIEF.md
# Wait-Lock Handoff Controller

This block manages a small set of long-held locks shared by up to four processors, so that no processor has to spin while a lock is busy. Each lock records whether it is held, which processor holds it, and a bitmask of processors queued behind it. A processor that asks for a busy lock is entered in that mask and can then go idle. When the holder lets go, the controller picks one queued processor and makes it the new holder. It clears that processor's bit in the mask and raises that processor's interprocessor interrupt line. The other queued processors are not woken, so they never race for the freed lock.

The same request path carries plain state-change notifications from any processor to any other, interrupt acknowledges, and restarts for a per-processor sanity timer. The timer raises a fault flag if its processor does not restart it within a programmable number of cycles. Requests from all processors pass through one round-robin arbiter, so exactly one operation takes effect per clock cycle. Its result is visible on the outputs after the next rising edge.

Top module: `wl_handoff_ctrl`

## Requirements
- R1: Processor i requests with `req_valid[i]` and opcode `req_op[3*i+:3]` (0 idle, 1 acquire, 2 release, 3 notify, 4 acknowledge, 5 timer restart). At most one `req_ready` bit is high in a cycle, only for a valid requester. When two requesters stay valid, the one not served is served in the next cycle. A granted operation shows on the outputs after the next rising edge.
- R2: An acquire of a free lock (index `req_lock[LW*i+:LW]`) makes the requester the holder: `lock_held[L]` goes high and `lock_owner[2*L+:2]` shows the requester's number.
- R3: An acquire of a lock held by another processor sets bit i of `lock_waiters[NCPU*L+:NCPU]`. An acquire by the current holder has no effect. The holder's own bit is never set.
- R4: A release by the holder while waiters are queued hands the lock to the first queued processor found when searching upward from the releaser's number plus one, wrapping past the highest number. That processor's waiter bit is cleared and its `ipi` bit is raised. The lock stays held throughout.
- R5: A release by the holder with no waiters frees the lock. `lock_held[L]` goes low, and the owner field and the waiter mask read zero.
- R6: A release by a processor that does not hold the lock changes no lock state and raises no interrupt.
- R7: A notify from any processor raises `ipi` for the processor numbered in `req_target[2*i+:2]`.
- R8: An `ipi` bit stays high until its own processor issues an acknowledge. An acknowledge with no interrupt pending changes nothing.
- R9: A restart from processor i clears `wd_fault[i]` and arms its timer. If no further restart arrives, `wd_fault[i]` rises on the edge that is `wd_limit`+1 cycles after the restart edge and stays high. A processor that has never restarted its timer shows no fault.
- R10: During and right after reset no lock is held, all waiter masks, owners and interrupt lines are zero, and no fault is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCPU | Request pending, one bit per processor |
| req_op | input | 3*NCPU | Opcode per processor |
| req_lock | input | LW*NCPU | Lock index per processor |
| req_target | input | 2*NCPU | Notify destination per processor |
| wd_limit | input | TW | Sanity timer limit in cycles |
| req_ready | output | NCPU | One-hot grant of this cycle's request |
| lock_held | output | NLOCK | Lock held flag per lock |
| lock_owner | output | 2*NLOCK | Holder number per lock |
| lock_waiters | output | NCPU*NLOCK | Queued processor mask per lock |
| ipi | output | NCPU | Interprocessor interrupt lines |
| wd_fault | output | NCPU | Sanity timer fault flags |

## Verification
The bench drives handoffs whose search has to wrap past the highest processor number. A design that scanned from zero, or from the releaser itself, would hand the lock to the wrong processor and raise the wrong interrupt. It sends releases from non-holders and repeat acquires from the holder, which a careless design would turn into a spurious handoff or a self-queued holder. It acknowledges with no interrupt pending, and checks that interrupts hold through idle cycles, to catch lines that clear by themselves or clear the wrong bit. It measures the timer fault edge to the cycle, which exposes off-by-one limit compares. It holds two requests at once and expects them served on consecutive cycles, which exposes a grant that is lost or doubled.

// File: rtl/wl_pkg.sv
package wl_pkg;

    localparam int CPU_W      = 2;
    localparam int MAX_CPU    = 1 << CPU_W;
    localparam int LOCK_IDX_W = 4;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_ACQ    = 3'd1,
        OP_REL    = 3'd2,
        OP_NOTE   = 3'd3,
        OP_ACK    = 3'd4,
        OP_KICK   = 3'd5
    } wl_op_e;

    typedef struct packed {
        logic                  valid;
        wl_op_e                op;
        logic [CPU_W-1:0]      src;
        logic [CPU_W-1:0]      dst;
        logic [LOCK_IDX_W-1:0] lock;
    } wl_cmd_t;

    // Returns {found, index} of the first set bit of mask met when scanning
    // upward from after+1, wrapping, with after itself examined last.
    function automatic logic [CPU_W:0] rr_pick(input logic [MAX_CPU-1:0] mask,
                                               input logic [CPU_W-1:0]   after);
        logic [CPU_W-1:0] idx;
        logic [CPU_W:0]   res;
        res = '0;
        for (int k = MAX_CPU; k >= 1; k--) begin
            idx = after + CPU_W'(k);
            if (mask[idx]) res = {1'b1, idx};
        end
        return res;
    endfunction

endpackage

// File: rtl/wl_arbiter.sv
module wl_arbiter
    import wl_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCPU-1:0]      valid,
    output logic [NCPU-1:0]      grant,
    output logic                 grant_any,
    output logic [CPU_W-1:0]     grant_idx
);

    logic [CPU_W-1:0]   last_q;
    logic [MAX_CPU-1:0] vmask;
    logic [CPU_W:0]     pick;

    always_comb begin
        vmask             = '0;
        vmask[NCPU-1:0]   = valid;
        pick              = rr_pick(vmask, last_q);
        grant_any         = pick[CPU_W];
        grant_idx         = pick[CPU_W-1:0];
    end

    for (genvar i = 0; i < NCPU; i++) begin : g_grant
        assign grant[i] = grant_any && (grant_idx == CPU_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)            last_q <= CPU_W'(MAX_CPU - 1);
        else if (grant_any) last_q <= grant_idx;
    end

endmodule

// File: rtl/wl_lock_slot.sv
module wl_lock_slot
    import wl_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int MYID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  wl_cmd_t           cmd,
    output logic              held,
    output logic [CPU_W-1:0]  owner,
    output logic [NCPU-1:0]   waiters,
    output logic              wake,
    output logic [CPU_W-1:0]  wake_cpu
);

    logic               held_q;
    logic [CPU_W-1:0]   owner_q;
    logic [MAX_CPU-1:0] wait_q;
    logic               hit;
    logic               by_owner;
    logic [CPU_W:0]     nxt;

    assign hit      = cmd.valid && (cmd.lock == LOCK_IDX_W'(MYID));
    assign by_owner = held_q && (owner_q == cmd.src);
    assign nxt      = rr_pick(wait_q, cmd.src);
    assign wake     = hit && (cmd.op == OP_REL) && by_owner && nxt[CPU_W];
    assign wake_cpu = nxt[CPU_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= 1'b0;
            owner_q <= '0;
            wait_q  <= '0;
        end else if (hit) begin
            unique case (cmd.op)
                OP_ACQ: begin
                    if (!held_q) begin
                        held_q  <= 1'b1;
                        owner_q <= cmd.src;
                    end else if (owner_q != cmd.src) begin
                        wait_q[cmd.src] <= 1'b1;
                    end
                end
                OP_REL: begin
                    if (by_owner) begin
                        if (nxt[CPU_W]) begin
                            owner_q                   <= nxt[CPU_W-1:0];
                            wait_q[nxt[CPU_W-1:0]]    <= 1'b0;
                        end else begin
                            held_q  <= 1'b0;
                            owner_q <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign held    = held_q;
    assign owner   = owner_q;
    assign waiters = wait_q[NCPU-1:0];

endmodule

// File: rtl/wl_sanity_timer.sv
module wl_sanity_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    input  logic [TW-1:0] limit,
    output logic          fault
);

    logic          armed_q;
    logic          fault_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            fault_q <= 1'b0;
            cnt_q   <= '0;
        end else if (kick) begin
            armed_q <= 1'b1;
            fault_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q && !fault_q) begin
            if (cnt_q == limit) fault_q <= 1'b1;
            else                cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign fault = fault_q;

endmodule

// File: rtl/wl_handoff_ctrl.sv
module wl_handoff_ctrl
    import wl_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NLOCK = 2,
    parameter int TW    = 16,
    localparam int LW   = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCPU-1:0]         req_valid,
    input  logic [3*NCPU-1:0]       req_op,
    input  logic [LW*NCPU-1:0]      req_lock,
    input  logic [CPU_W*NCPU-1:0]   req_target,
    input  logic [TW-1:0]           wd_limit,
    output logic [NCPU-1:0]         req_ready,
    output logic [NLOCK-1:0]        lock_held,
    output logic [CPU_W*NLOCK-1:0]  lock_owner,
    output logic [NCPU*NLOCK-1:0]   lock_waiters,
    output logic [NCPU-1:0]         ipi,
    output logic [NCPU-1:0]         wd_fault
);

    logic             g_any;
    logic [CPU_W-1:0] g_idx;
    wl_cmd_t          cmd;

    wl_arbiter #(.NCPU(NCPU)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .valid     (req_valid),
        .grant     (req_ready),
        .grant_any (g_any),
        .grant_idx (g_idx)
    );

    always_comb begin
        cmd.valid = g_any;
        cmd.op    = wl_op_e'(req_op[3*g_idx +: 3]);
        cmd.src   = g_idx;
        cmd.dst   = req_target[CPU_W*g_idx +: CPU_W];
        cmd.lock  = LOCK_IDX_W'(req_lock[LW*g_idx +: LW]);
    end

    logic [NLOCK-1:0]       wake_l;
    logic [CPU_W*NLOCK-1:0] wake_cpu_l;

    for (genvar l = 0; l < NLOCK; l++) begin : g_lock
        wl_lock_slot #(.NCPU(NCPU), .MYID(l)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd),
            .held     (lock_held[l]),
            .owner    (lock_owner[CPU_W*l +: CPU_W]),
            .waiters  (lock_waiters[NCPU*l +: NCPU]),
            .wake     (wake_l[l]),
            .wake_cpu (wake_cpu_l[CPU_W*l +: CPU_W])
        );
    end

    logic [NCPU-1:0] wake_vec;
    always_comb begin
        wake_vec = '0;
        for (int l = 0; l < NLOCK; l++) begin
            for (int c = 0; c < NCPU; c++) begin
                if (wake_l[l] && (wake_cpu_l[CPU_W*l +: CPU_W] == CPU_W'(c)))
                    wake_vec[c] = 1'b1;
            end
        end
    end

    logic [NCPU-1:0] ipi_q;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic note_me, ack_me, kick_me;
        assign note_me = cmd.valid && (cmd.op == OP_NOTE) && (cmd.dst == CPU_W'(c));
        assign ack_me  = cmd.valid && (cmd.op == OP_ACK)  && (cmd.src == CPU_W'(c));
        assign kick_me = cmd.valid && (cmd.op == OP_KICK) && (cmd.src == CPU_W'(c));

        always_ff @(posedge clk) begin
            if (rst)                          ipi_q[c] <= 1'b0;
            else if (wake_vec[c] || note_me)  ipi_q[c] <= 1'b1;
            else if (ack_me)                  ipi_q[c] <= 1'b0;
        end

        wl_sanity_timer #(.TW(TW)) u_wd (
            .clk   (clk),
            .rst   (rst),
            .kick  (kick_me),
            .limit (wd_limit),
            .fault (wd_fault[c])
        );
    end

    assign ipi = ipi_q;

endmodule

// File: rtl/wl_handoff_checker.sv
module wl_handoff_checker
    import wl_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int NLOCK = 2,
    parameter int TW    = 16,
    localparam int LW   = (NLOCK > 1) ? $clog2(NLOCK) : 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NCPU-1:0]         req_valid,
    input logic [3*NCPU-1:0]       req_op,
    input logic [LW*NCPU-1:0]      req_lock,
    input logic [CPU_W*NCPU-1:0]   req_target,
    input logic [TW-1:0]           wd_limit,
    input logic [NCPU-1:0]         req_ready,
    input logic [NLOCK-1:0]        lock_held,
    input logic [CPU_W*NLOCK-1:0]  lock_owner,
    input logic [NCPU*NLOCK-1:0]   lock_waiters,
    input logic [NCPU-1:0]         ipi,
    input logic [NCPU-1:0]         wd_fault
);

    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    a_r1_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_ready & ~req_valid) == '0);

    for (genvar l = 0; l < NLOCK; l++) begin : g_l
        a_r3_owner_not_queued: assert property (@(posedge clk) disable iff (rst)
            lock_held[l] |-> !lock_waiters[NCPU*l + int'(lock_owner[CPU_W*l +: CPU_W])]);

        a_r5_free_is_clean: assert property (@(posedge clk) disable iff (rst)
            !lock_held[l] |-> (lock_waiters[NCPU*l +: NCPU] == '0 &&
                               lock_owner[CPU_W*l +: CPU_W] == '0));

        a_r4_stays_held_with_waiters: assert property (@(posedge clk) disable iff (rst)
            (lock_held[l] && |lock_waiters[NCPU*l +: NCPU]) |=> lock_held[l]);
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_c
        a_r7_ipi_rise_needs_grant: assert property (@(posedge clk) disable iff (rst)
            $rose(ipi[c]) |-> $past(|req_ready));

        a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (req_ready[c] && req_op[3*c +: 3] == 3'd4) |=> !ipi[c]);

        a_r9_kick_clears_fault: assert property (@(posedge clk) disable iff (rst)
            (req_ready[c] && req_op[3*c +: 3] == 3'd5) |=> !wd_fault[c]);
    end

endmodule

bind wl_handoff_ctrl wl_handoff_checker #(.NCPU(NCPU), .NLOCK(NLOCK), .TW(TW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_lock     (req_lock),
    .req_target   (req_target),
    .wd_limit     (wd_limit),
    .req_ready    (req_ready),
    .lock_held    (lock_held),
    .lock_owner   (lock_owner),
    .lock_waiters (lock_waiters),
    .ipi          (ipi),
    .wd_fault     (wd_fault)
);

// File: tb/sim_wl_handoff_ctrl.sv
`timescale 1ns/1ps
module sim_wl_handoff_ctrl;

    localparam int NCPU  = 4;
    localparam int NLOCK = 2;
    localparam int TW    = 16;
    localparam int LW    = 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NCPU-1:0]      req_valid = '0;
    logic [3*NCPU-1:0]    req_op = '0;
    logic [LW*NCPU-1:0]   req_lock = '0;
    logic [2*NCPU-1:0]    req_target = '0;
    logic [TW-1:0]        wd_limit = 16'd5;
    logic [NCPU-1:0]      req_ready;
    logic [NLOCK-1:0]     lock_held;
    logic [2*NLOCK-1:0]   lock_owner;
    logic [NCPU*NLOCK-1:0] lock_waiters;
    logic [NCPU-1:0]      ipi;
    logic [NCPU-1:0]      wd_fault;

    always #2 clk = ~clk;

    wl_handoff_ctrl #(.NCPU(NCPU), .NLOCK(NLOCK), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_lock(req_lock), .req_target(req_target), .wd_limit(wd_limit),
        .req_ready(req_ready), .lock_held(lock_held), .lock_owner(lock_owner),
        .lock_waiters(lock_waiters), .ipi(ipi), .wd_fault(wd_fault)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input int cpu, input logic [2:0] op, input logic lk, input logic [1:0] tgt);
        @(negedge clk);
        req_valid                = '0;
        req_valid[cpu]           = 1'b1;
        req_op[3*cpu +: 3]       = op;
        req_lock[cpu]            = lk;
        req_target[2*cpu +: 2]   = tgt;
        @(posedge clk);
        #1;
        req_valid = '0;
    endtask

    typedef struct packed {
        logic [1:0] cpu;
        logic [2:0] op;
        logic       lk;
        logic [1:0] tgt;
        logic       own0;
        logic [1:0] owner0;
        logic [3:0] wait0;
        logic       own1;
        logic [3:0] ipi;
    } vec_t;

    localparam vec_t VEC [0:17] = '{
        '{2'd0, 3'd1, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0000}, // R2 free acquire
        '{2'd1, 3'd1, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0010, 1'b0, 4'b0000}, // R3 queue
        '{2'd3, 3'd1, 1'b0, 2'd0, 1'b1, 2'd0, 4'b1010, 1'b0, 4'b0000}, // R3 queue
        '{2'd2, 3'd2, 1'b0, 2'd0, 1'b1, 2'd0, 4'b1010, 1'b0, 4'b0000}, // R6 non-owner release
        '{2'd0, 3'd2, 1'b0, 2'd0, 1'b1, 2'd1, 4'b1000, 1'b0, 4'b0010}, // R4 handoff to 1
        '{2'd1, 3'd4, 1'b0, 2'd0, 1'b1, 2'd1, 4'b1000, 1'b0, 4'b0000}, // R8 ack
        '{2'd0, 3'd1, 1'b0, 2'd0, 1'b1, 2'd1, 4'b1001, 1'b0, 4'b0000}, // R3 queue
        '{2'd1, 3'd2, 1'b0, 2'd0, 1'b1, 2'd3, 4'b0001, 1'b0, 4'b1000}, // R4 skips 2, picks 3
        '{2'd3, 3'd4, 1'b0, 2'd0, 1'b1, 2'd3, 4'b0001, 1'b0, 4'b0000}, // R8 ack
        '{2'd3, 3'd1, 1'b0, 2'd0, 1'b1, 2'd3, 4'b0001, 1'b0, 4'b0000}, // R3 holder re-acquire
        '{2'd3, 3'd2, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0001}, // R4 wraps to 0
        '{2'd2, 3'd3, 1'b0, 2'd1, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0011}, // R7 notify 1
        '{2'd2, 3'd4, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0011}, // R8 stale ack
        '{2'd0, 3'd4, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0010}, // R8 ack
        '{2'd1, 3'd4, 1'b0, 2'd0, 1'b1, 2'd0, 4'b0000, 1'b0, 4'b0000}, // R8 ack
        '{2'd0, 3'd2, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000}, // R5 free
        '{2'd2, 3'd1, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b1, 4'b0000}, // R2 second lock
        '{2'd2, 3'd2, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0000, 1'b0, 4'b0000}  // R5 second lock
    };

    initial begin
        int w, o;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 held",    32'(lock_held),    32'd0);
        chk("R10 waiters", 32'(lock_waiters), 32'd0);
        chk("R10 ipi",     32'(ipi),          32'd0);
        chk("R10 fault",   32'(wd_fault),     32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 owner after reset", 32'(lock_owner), 32'd0);

        for (int s = 0; s < 18; s++) begin
            issue(int'(VEC[s].cpu), VEC[s].op, VEC[s].lk, VEC[s].tgt);
            chk($sformatf("R2..table step %0d held0", s), 32'(lock_held[0]), 32'(VEC[s].own0));
            chk($sformatf("table step %0d owner0", s), 32'(lock_owner[1:0]), 32'(VEC[s].owner0));
            chk($sformatf("table step %0d waiters0", s), 32'(lock_waiters[3:0]), 32'(VEC[s].wait0));
            chk($sformatf("table step %0d held1", s), 32'(lock_held[1]), 32'(VEC[s].own1));
            chk($sformatf("table step %0d ipi", s), 32'(ipi), 32'(VEC[s].ipi));
        end

        // R8 interrupt holds through idle cycles
        issue(0, 3'd3, 1'b0, 2'd3);
        repeat (5) @(posedge clk);
        #1;
        chk("R8 ipi held while idle", 32'(ipi), 32'b1000);
        issue(3, 3'd4, 1'b0, 2'd0);
        chk("R8 ipi cleared by ack", 32'(ipi), 32'd0);

        // R1 two requesters at once
        @(negedge clk);
        req_valid    = 4'b0110;
        req_op[3+:3] = 3'd1;
        req_op[6+:3] = 3'd1;
        req_lock[1]  = 1'b1;
        req_lock[2]  = 1'b1;
        #1;
        chk("R1 one grant", 32'($countones(req_ready)), 32'd1);
        w = req_ready[1] ? 1 : 2;
        o = 3 - w;
        @(posedge clk);
        #1;
        req_valid[w] = 1'b0;
        chk("R1 other served next", 32'(req_ready), 32'(1 << o));
        @(posedge clk);
        #1;
        req_valid = '0;
        chk("R1 winner holds", 32'(lock_owner[3:2]), 32'(w));
        chk("R1 loser queued", 32'(lock_waiters[7:4]), 32'(1 << o));
        issue(w, 3'd2, 1'b1, 2'd0);
        chk("R4 handoff lock1", 32'(lock_owner[3:2]), 32'(o));
        chk("R4 handoff ipi", 32'(ipi), 32'(1 << o));
        issue(o, 3'd4, 1'b0, 2'd0);
        issue(o, 3'd2, 1'b1, 2'd0);
        chk("R5 lock1 freed", 32'(lock_held[1]), 32'd0);

        // R9 sanity timer, limit 5
        issue(2, 3'd5, 1'b0, 2'd0);
        repeat (5) @(posedge clk);
        #1;
        chk("R9 no fault at limit", 32'(wd_fault), 32'd0);
        @(posedge clk);
        #1;
        chk("R9 fault at limit+1", 32'(wd_fault), 32'b0100);
        repeat (3) @(posedge clk);
        #1;
        chk("R9 fault sticky, unarmed clean", 32'(wd_fault), 32'b0100);
        issue(2, 3'd5, 1'b0, 2'd0);
        chk("R9 restart clears", 32'(wd_fault), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule